// File: doc/BRIEF.md
# Four-Leg Symmetric Switching Sequencer

This block drives the four upper-switch gate signals of a two-level, four-leg inverter. The three phase legs are sa, sb and sc, and sf is the fourth (neutral) leg. A modulator upstream picks three non-zero switching vectors that bound the reference voltage. It passes their gate codes to this block together with a half-dwell count for each one. The block turns these into one switching period of `PERIOD` clock ticks. The period opens and closes on the all-off zero vector. The three non-zero vectors sit in a mirrored pattern about the period centre, and the last of them occupies the middle of the period.

The three codes are meant to form a chain. The first code has one gate bit set, and each following code adds one more bit. With such a chain, every step of the sequence toggles exactly one leg. New codes and counts are taken only on the clock edge that begins a period. The host may therefore change its inputs at any time during a period. Lower-switch complements, dead time and fault handling sit outside this block.

Top module: `fourleg_pwm_seq`

## Requirements
- R1: A gate code is four bits {sf, sa, sb, sc}, with sf in bit 3 and sc in bit 0. Vector number n has code n−1, so the zero vector is 4'b0000. Each output pin carries its own bit of the code being applied.
- R2: While rst_n is low at a rising edge, all four gates go low after that edge and period_start_o goes high.
- R3: period_start_o is high for exactly one tick in every `PERIOD` ticks, and it marks tick 0 of a period. After reset is released, the tick on which rst_n is first seen high is tick 0.
- R4: Tick p of a period is folded to q = p for p < PERIOD/2, and to q = PERIOD−1−p otherwise. Let k = PERIOD/2−1−q. The third vector is applied when k < span3. Otherwise the second vector is applied when k < span3+span2. Otherwise the first vector is applied when k < span3+span2+span1. In all other cases the zero vector is applied.
- R5: Within one period, the gate code at tick p equals the gate code at tick PERIOD−1−p.
- R6: Codes and spans are captured on the edge that starts a period. Input changes at any other time have no effect on the current period.
- R7: When span1+span2+span3 exceeds PERIOD/2, the vectors nearer the centre keep their full share. The zero vector is removed first, then the first vector, then the second, following the R4 rule.
- R8: A vector with a zero span never appears. The gates only ever show the zero vector or one of the three captured codes, with no one-tick intermediate pattern.
- R9: If the captured codes form a one-bit chain from 4'b0000 and all three spans are non-zero, every change of the gate pattern within a period flips exactly one leg.
- R10: When span1+span2+span3 is less than PERIOD/2, the first and last ticks of the period apply the zero vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec1_code_i | input | 4 | Gate code of the first non-zero vector |
| vec2_code_i | input | 4 | Gate code of the second non-zero vector |
| vec3_code_i | input | 4 | Gate code of the centre vector |
| vec1_span_i | input | SPAN_W | Half-dwell of the first vector, in ticks |
| vec2_span_i | input | SPAN_W | Half-dwell of the second vector, in ticks |
| vec3_span_i | input | SPAN_W | Half-dwell of the centre vector, in ticks |
| gate_sa_o | output | 1 | Upper gate of leg a |
| gate_sb_o | output | 1 | Upper gate of leg b |
| gate_sc_o | output | 1 | Upper gate of leg c |
| gate_sf_o | output | 1 | Upper gate of the fourth (neutral) leg |
| period_start_o | output | 1 | High on tick 0 of each period |

## Verification
The hardest condition to create from the ports is an operand change that lands inside a period. Such a change must leave the running period untouched, and the next period must pick it up. To reach it, the stimulus drives unrelated decoy codes and spans during the first half of every period. It then places the real next operands at the midpoint, and each period is compared tick by tick against a model of the intended layout. The stimulus also mixes in spans of zero and span sums above half a period. These reach the truncation and skipped-vector cases, where glitches or wrong precedence would show up.

// File: rtl/fls_pkg.sv
// Shared gate-code type and leg bit positions for the four-leg sequencer.
// Assumes a code of four upper-gate bits with the neutral leg as MSB.
package fls_pkg;
    typedef logic [3:0] gate_code_t;

    localparam int LEG_SF = 3;
    localparam int LEG_SA = 2;
    localparam int LEG_SB = 1;
    localparam int LEG_SC = 0;

    localparam gate_code_t ZERO_VEC = 4'b0000;

    // True when two codes differ in exactly one leg.
    function automatic logic one_leg_apart(gate_code_t a, gate_code_t b);
        return ($countones(a ^ b) == 1);
    endfunction
endpackage

// File: rtl/fls_tick_counter.sv
// Period tick counter: counts 0..PERIOD-1 and wraps.
// Exposes the next count so downstream logic can register outputs aligned
// with the count. Assumes PERIOD is even and at least 4.
module fls_tick_counter #(
    parameter int PERIOD = 64,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_next,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    // Detect the final tick and form the following count.
    always_comb begin
        wrap     = (cnt_q == LAST);
        cnt_next = wrap ? '0 : cnt_q + CNT_W'(1);
    end

    // Hold the current tick within the period.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R3
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(cnt_q) == LAST) |-> (cnt_q == '0));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(cnt_q) != LAST) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/fls_operand_latch.sv
// Shadow registers for the three vector codes and spans.
// Captures the inputs only when load is high (the period-start edge) and
// offers the value that will be held after the next edge.
module fls_operand_latch
    import fls_pkg::*;
#(
    parameter int SPAN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  gate_code_t        code1_i,
    input  gate_code_t        code2_i,
    input  gate_code_t        code3_i,
    input  logic [SPAN_W-1:0] span1_i,
    input  logic [SPAN_W-1:0] span2_i,
    input  logic [SPAN_W-1:0] span3_i,
    output gate_code_t        code1_q,
    output gate_code_t        code2_q,
    output gate_code_t        code3_q,
    output logic [SPAN_W-1:0] span1_q,
    output logic [SPAN_W-1:0] span2_q,
    output logic [SPAN_W-1:0] span3_q,
    output gate_code_t        code1_n,
    output gate_code_t        code2_n,
    output gate_code_t        code3_n,
    output logic [SPAN_W-1:0] span1_n,
    output logic [SPAN_W-1:0] span2_n,
    output logic [SPAN_W-1:0] span3_n
);
    // Select between holding and taking new operands.
    always_comb begin
        code1_n = load ? code1_i : code1_q;
        code2_n = load ? code2_i : code2_q;
        code3_n = load ? code3_i : code3_q;
        span1_n = load ? span1_i : span1_q;
        span2_n = load ? span2_i : span2_q;
        span3_n = load ? span3_i : span3_q;
    end

    // Register the operands used by the running period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code1_q <= ZERO_VEC;
            code2_q <= ZERO_VEC;
            code3_q <= ZERO_VEC;
            span1_q <= '0;
            span2_q <= '0;
            span3_q <= '0;
        end else begin
            code1_q <= code1_n;
            code2_q <= code2_n;
            code3_q <= code3_n;
            span1_q <= span1_n;
            span2_q <= span2_n;
            span3_q <= span3_n;
        end
    end

    // R6
    ops_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(load)
        |-> $stable({code1_q, code2_q, code3_q, span1_q, span2_q, span3_q}));
endmodule

// File: rtl/fls_slot_decode.sv
// Maps a tick position to the gate code to apply.
// The tick is folded about the period centre. Fixed thresholds measured
// back from the centre give the centre vector priority, then the second,
// then the first; whatever is left is the zero vector.
// Purely combinational; assumes PERIOD is even.
module fls_slot_decode
    import fls_pkg::*;
#(
    parameter int PERIOD = 64,
    parameter int SPAN_W = 6,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic [CNT_W-1:0]  pos,
    input  gate_code_t        code1,
    input  gate_code_t        code2,
    input  gate_code_t        code3,
    input  logic [SPAN_W-1:0] span1,
    input  logic [SPAN_W-1:0] span2,
    input  logic [SPAN_W-1:0] span3,
    output gate_code_t        code_o
);
    localparam int HALF = PERIOD / 2;
    localparam int TW   = ((CNT_W > SPAN_W) ? CNT_W : SPAN_W) + 3;

    logic [CNT_W-1:0]     fold;
    logic signed [TW-1:0] fold_s;
    logic signed [TW-1:0] edge1;
    logic signed [TW-1:0] edge2;
    logic signed [TW-1:0] edge3;

    // Fold the second half onto the first to get mirror symmetry.
    always_comb begin
        if (pos < CNT_W'(HALF)) fold = pos;
        else                    fold = CNT_W'(PERIOD - 1) - pos;
        fold_s = $signed(TW'(fold));
    end

    // Start of each vector's slot within the half period (may be negative).
    always_comb begin
        edge3 = $signed(TW'(HALF)) - $signed(TW'(span3));
        edge2 = edge3 - $signed(TW'(span2));
        edge1 = edge2 - $signed(TW'(span1));
    end

    // Pick the vector whose slot holds the folded tick.
    always_comb begin
        if (fold_s >= edge3)      code_o = code3;
        else if (fold_s >= edge2) code_o = code2;
        else if (fold_s >= edge1) code_o = code1;
        else                      code_o = ZERO_VEC;
    end
endmodule

// File: rtl/fourleg_pwm_seq.sv
// Four-leg symmetric switching sequencer.
// Each period is zero vector, V1st, V2nd, centre, V2nd, V1st, zero vector,
// with the dwell of each vector taken from its half-span input. Operands
// are captured on the period-start edge. Gate outputs are registered from
// the next tick and next operands, so they change only on clock edges.
// Assumes an even PERIOD; no dead time or complements are produced here.
module fourleg_pwm_seq
    import fls_pkg::*;
#(
    parameter int PERIOD = 64,
    parameter int SPAN_W = $clog2(PERIOD / 2) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        vec1_code_i,
    input  logic [3:0]        vec2_code_i,
    input  logic [3:0]        vec3_code_i,
    input  logic [SPAN_W-1:0] vec1_span_i,
    input  logic [SPAN_W-1:0] vec2_span_i,
    input  logic [SPAN_W-1:0] vec3_span_i,
    output logic              gate_sa_o,
    output logic              gate_sb_o,
    output logic              gate_sc_o,
    output logic              gate_sf_o,
    output logic              period_start_o
);
    localparam int HALF  = PERIOD / 2;
    localparam int CNT_W = $clog2(PERIOD);
    localparam int SUM_W = SPAN_W + 2;

    logic [CNT_W-1:0]  cnt_next;
    logic              wrap;
    gate_code_t        c1_q, c2_q, c3_q, c1_n, c2_n, c3_n;
    logic [SPAN_W-1:0] s1_q, s2_q, s3_q, s1_n, s2_n, s3_n;
    gate_code_t        code_next;
    gate_code_t        gates_q;
    logic              start_q;

    fls_tick_counter #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_next (cnt_next),
        .wrap     (wrap)
    );

    fls_operand_latch #(.SPAN_W(SPAN_W)) u_ops (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wrap),
        .code1_i (vec1_code_i),
        .code2_i (vec2_code_i),
        .code3_i (vec3_code_i),
        .span1_i (vec1_span_i),
        .span2_i (vec2_span_i),
        .span3_i (vec3_span_i),
        .code1_q (c1_q),
        .code2_q (c2_q),
        .code3_q (c3_q),
        .span1_q (s1_q),
        .span2_q (s2_q),
        .span3_q (s3_q),
        .code1_n (c1_n),
        .code2_n (c2_n),
        .code3_n (c3_n),
        .span1_n (s1_n),
        .span2_n (s2_n),
        .span3_n (s3_n)
    );

    fls_slot_decode #(.PERIOD(PERIOD), .SPAN_W(SPAN_W), .CNT_W(CNT_W)) u_dec (
        .pos    (cnt_next),
        .code1  (c1_n),
        .code2  (c2_n),
        .code3  (c3_n),
        .span1  (s1_n),
        .span2  (s2_n),
        .span3  (s3_n),
        .code_o (code_next)
    );

    // Register the gate pattern and the period-start marker together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gates_q <= ZERO_VEC;
            start_q <= 1'b1;
        end else begin
            gates_q <= code_next;
            start_q <= (cnt_next == '0);
        end
    end

    // Drive each leg pin from its bit of the code.
    always_comb begin
        gate_sf_o      = gates_q[LEG_SF];
        gate_sa_o      = gates_q[LEG_SA];
        gate_sb_o      = gates_q[LEG_SB];
        gate_sc_o      = gates_q[LEG_SC];
        period_start_o = start_q;
    end

    // Assertion helpers: span total and chain shape of the held operands.
    logic [SUM_W-1:0] span_sum;
    logic             chain_ok;
    always_comb begin
        span_sum = SUM_W'(s1_q) + SUM_W'(s2_q) + SUM_W'(s3_q);
        chain_ok = one_leg_apart(ZERO_VEC, c1_q) && one_leg_apart(c1_q, c2_q)
                && one_leg_apart(c2_q, c3_q)
                && (s1_q != '0) && (s2_q != '0) && (s3_q != '0);
    end

    // R8
    gate_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gates_q == ZERO_VEC) || (gates_q == c1_q) || (gates_q == c2_q) || (gates_q == c3_q));

    // R9
    one_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chain_ok && !start_q |-> ($countones(gates_q ^ $past(gates_q)) <= 1));

    // R10
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q && (span_sum < SUM_W'(HALF)) |-> (gates_q == ZERO_VEC));
endmodule

// File: tb/sim_fourleg_pwm_seq.sv
`timescale 1ns/1ps
module sim_fourleg_pwm_seq;
    localparam int PERIOD = 64;
    localparam int HALF   = PERIOD / 2;
    localparam int SW     = 6;
    localparam int NPER   = 70;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] c1_i, c2_i, c3_i;
    logic [SW-1:0] s1_i, s2_i, s3_i;
    logic sa, sb, sc, sf, pstart;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int seed_v;

    logic [3:0] nc1, nc2, nc3, ac1, ac2, ac3;
    int ns1, ns2, ns3, as1, as2, as3;
    logic [3:0] smp [PERIOD];
    logic [3:0] pins_mid;

    fourleg_pwm_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .vec1_code_i(c1_i), .vec2_code_i(c2_i), .vec3_code_i(c3_i),
        .vec1_span_i(s1_i), .vec2_span_i(s2_i), .vec3_span_i(s3_i),
        .gate_sa_o(sa), .gate_sb_o(sb), .gate_sc_o(sc), .gate_sf_o(sf),
        .period_start_o(pstart)
    );

    always #10 clk = ~clk;

    task automatic check(string tag, int actual, int expected, string what);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
        end
    endtask

    // Layout model: distance from the centre decides the vector.
    function automatic logic [3:0] expect_code(logic [3:0] a, logic [3:0] b, logic [3:0] c,
                                               int x1, int x2, int x3, int p);
        int q = (p < HALF) ? p : PERIOD - 1 - p;
        int k = HALF - 1 - q;
        if (k < x3) return c;
        if (k < x3 + x2) return b;
        if (k < x3 + x2 + x1) return a;
        return 4'b0000;
    endfunction

    task automatic drive(logic [3:0] a, logic [3:0] b, logic [3:0] c, int x1, int x2, int x3);
        c1_i = a; c2_i = b; c3_i = c;
        s1_i = SW'(x1); s2_i = SW'(x2); s3_i = SW'(x3);
    endtask

    task automatic random_chain();
        int perm [4];
        for (int i = 0; i < 4; i++) perm[i] = i;
        for (int i = 3; i > 0; i--) begin
            int j = $urandom_range(i, 0);
            int t = perm[i];
            perm[i] = perm[j];
            perm[j] = t;
        end
        nc1 = 4'(1 << perm[0]);
        nc2 = nc1 | 4'(1 << perm[1]);
        nc3 = nc2 | 4'(1 << perm[2]);
    endtask

    // Choose the operands for the period after period k.
    task automatic pick(int k);
        nc1 = 4'b1000; nc2 = 4'b1100; nc3 = 4'b1110;
        case (k)
            0: begin ns1 = 4;  ns2 = 3;  ns3 = 2;  end
            1: begin ns1 = 0;  ns2 = 5;  ns3 = 5;  end
            2: begin ns1 = 7;  ns2 = 0;  ns3 = 3;  end
            3: begin ns1 = 5;  ns2 = 5;  ns3 = 0;  end
            4: begin ns1 = 10; ns2 = 10; ns3 = 12; end
            5: begin ns1 = 63; ns2 = 63; ns3 = 63; end
            6: begin ns1 = 0;  ns2 = 0;  ns3 = 0;  end
            7: begin ns1 = 20; ns2 = 20; ns3 = 20; end
            default: begin
                int mode = $urandom_range(9, 0);
                random_chain();
                if (mode < 8) begin
                    ns1 = 1 + $urandom_range(9, 0);
                    ns2 = 1 + $urandom_range(9, 0);
                    ns3 = 1 + $urandom_range(9, 0);
                    if (mode == 6) ns2 = 0;
                    if (mode == 7) ns1 = 0;
                end else begin
                    ns1 = $urandom_range(63, 0);
                    ns2 = $urandom_range(63, 0);
                    ns3 = $urandom_range(63, 0);
                end
            end
        endcase
    endtask

    initial begin
        seed_v = $urandom(32'd1357);
        nc1 = '0; nc2 = '0; nc3 = '0; ns1 = 0; ns2 = 0; ns3 = 0;
        drive(4'b0, 4'b0, 4'b0, 0, 0, 0);
        repeat (4) @(negedge clk);
        // R2: reset state
        check("R2", {sf, sa, sb, sc}, 0, "gates in reset");
        check("R2", pstart, 1, "period start in reset");
        rst_n = 1'b1;
        for (int k = 0; k < NPER; k++) begin
            int mism_first = 0;
            int bad_step = 0;
            int asym = 0;
            string tag;
            check("R3", pstart, 1, "period start at tick 0");
            ac1 = nc1; ac2 = nc2; ac3 = nc3; as1 = ns1; as2 = ns2; as3 = ns3;
            if (as1 + as2 + as3 > HALF) tag = "R7";
            else if (as1 == 0 || as2 == 0 || as3 == 0) tag = "R8";
            else tag = "R4";
            // R6: decoy operands that must not reach this period
            drive(4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)),
                  $urandom_range(63, 0), $urandom_range(63, 0), $urandom_range(63, 0));
            for (int p = 0; p < PERIOD; p++) begin
                logic [3:0] ex;
                if (p > 0) @(negedge clk);
                if (p == HALF) begin
                    pick(k);
                    drive(nc1, nc2, nc3, ns1, ns2, ns3);
                end
                smp[p] = {sf, sa, sb, sc};
                if (p == HALF - 1) pins_mid = {sf, sa, sb, sc};
                ex = expect_code(ac1, ac2, ac3, as1, as2, as3, p);
                check(tag, smp[p], ex, $sformatf("gate code at tick %0d of period %0d", p, k));
                if (p < HALF && smp[p] != ex) mism_first++;
                if (p > 0) check("R3", pstart, 0, "period start off mid-period");
            end
            check("R6", mism_first, 0, "ticks disturbed by mid-period operand change");
            for (int p = 0; p < HALF; p++)
                if (smp[p] != smp[PERIOD - 1 - p]) asym++;
            check("R5", asym, 0, "mirror mismatches");
            if (ac1 != 0 && as1 > 0 && as2 > 0 && as3 > 0) begin
                for (int p = 1; p < PERIOD; p++)
                    if ($countones(smp[p] ^ smp[p - 1]) > 1) bad_step++;
                check("R9", bad_step, 0, "transitions flipping more than one leg");
            end
            if (as1 + as2 + as3 < HALF) begin
                check("R10", smp[0], 0, "first tick vector");
                check("R10", smp[PERIOD - 1], 0, "last tick vector");
            end
            if (as3 > 0) check("R1", pins_mid, ac3, "pins {sf,sa,sb,sc} at centre");
            @(negedge clk);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule